// File: doc/BRIEF.md
# Coincidence Detector Counter Bank

This block tallies how often each combination of detector channels fires together. A reference pulse clock drives every register. On each rising edge the block registers which detector lines have just gone high after being low. It treats that set of flags as a binary number and, in count mode, adds one to the 40-bit counter at that number. Pulses on which no detector newly fired are tallied in counter 0.

A separate 40-bit run counter holds the number of pulses still to be counted. The host loads it one byte at a time through five byte strobes. Each counted pulse decrements it. While it is nonzero the block counts and raises a running flag. When it reaches zero the flag drops and further count pulses are ignored. A clear command zeroes every counter. Any counter, or the run counter, can be read at any time through a combinational index port.

Top module: `coinc_bank`

## Requirements
- R1: During and after reset, every coincidence counter and the run counter read zero and `running` is low.
- R2: A detector bit is flagged as newly fired on an edge only if it is high at that edge and was low at the previous edge. A line held high over several edges is flagged once, and again only after it has been seen low. Before the first edge after reset, no bit can be flagged.
- R3: The counter index is the flagged vector read as a binary number, with `det_i[0]` as bit 0. Index 0 is used when no bit is flagged. A vector sampled on one edge is counted on the next edge that counts.
- R4: On an edge with `count_en` high, `clear_all` low, no preset strobe and a nonzero run counter, the indexed counter increments by one, the run counter decrements by one and `running` goes high.
- R5: On a count edge with the run counter at zero, no counter changes and `running` goes low.
- R6: `clear_all` zeroes every counter, including the run counter, and drops `running`. It takes priority over preset and count.
- R7: `preset_stb[k]` loads `preset_byte` into bits 8k+7..8k of the run counter, where k=0 is the least significant byte. The other bytes are left unchanged. A preset edge does not count, even if `count_en` is high.
- R8: On an edge with no command, all counters and `running` hold their values.
- R9: `rd_value` shows coincidence counter `rd_idx` when `rd_idx` < 2^N_DET, the run counter when `rd_idx` = 2^N_DET, and zero for any larger index, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pulse clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_i | input | N_DET | Detector lines, bit 0 is detector A |
| count_en | input | 1 | Count command |
| clear_all | input | 1 | Clear-all command |
| preset_stb | input | 5 | One strobe per run-counter byte, bit 0 loads the least significant byte |
| preset_byte | input | 8 | Data byte for run-counter preset |
| rd_idx | input | N_DET+1 | Counter select for the read port |
| rd_value | output | 40 | Selected counter value |
| running | output | 1 | High while counting with pulses left |

## Verification
Detector lines go through one register stage before they select a counter. A detector pattern applied before edge e is therefore tallied at edge e+1, and only if that edge counts. Commands take effect on the edge that samples them, and `running` and the run counter are updated on that same edge. The read port has no latency. The bench drives inputs at the falling edge. At the next falling edge it compares every read index and `running` against a behavioural model that it advances on each rising edge, so each result is checked half a cycle after the edge that produces it.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_PRESET = 2'd2,
    OP_COUNT  = 2'd3
  } op_e;
endpackage

// File: rtl/coinc_edge.sv
// Flags detector lines that rose since the previous pulse edge.
module coinc_edge #(
  parameter int N_DET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DET-1:0] det_i,
  output logic [N_DET-1:0] fresh_o
);
  logic [N_DET-1:0] armed_q, armed_d;
  logic [N_DET-1:0] fresh_q, fresh_d;

  always_comb begin
    fresh_d = det_i & armed_q;
    armed_d = ~det_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= '0;
      fresh_q <= '0;
    end else begin
      armed_q <= armed_d;
      fresh_q <= fresh_d;
    end
  end

  assign fresh_o = fresh_q;
endmodule

// File: rtl/coinc_run_ctr.sv
// Run counter: byte-wise preset, decrement per counted pulse, running flag.
module coinc_run_ctr
  import coinc_pkg::*;
#(
  parameter int CNT_W = 40,
  localparam int NB = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  input  logic [NB-1:0]    preset_stb,
  input  logic [7:0]       preset_byte,
  output logic [CNT_W-1:0] run_o,
  output logic             live_o,
  output logic             running_o
);
  logic [CNT_W-1:0] run_q, run_d;
  logic             running_q, running_d;
  logic             live;
  logic             en;

  assign live = (run_q != '0);
  assign en   = (op != OP_IDLE);

  always_comb begin
    run_d     = run_q;
    running_d = running_q;
    case (op)
      OP_CLEAR: begin
        run_d     = '0;
        running_d = 1'b0;
      end
      OP_PRESET: begin
        for (int b = 0; b < NB; b++) begin
          if (preset_stb[b]) run_d[8*b +: 8] = preset_byte;
        end
      end
      OP_COUNT: begin
        running_d = live;
        if (live) run_d = run_q - CNT_W'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      running_q <= 1'b0;
    end else if (en) begin
      run_q     <= run_d;
      running_q <= running_d;
    end
  end

  assign run_o     = run_q;
  assign live_o    = live;
  assign running_o = running_q;
endmodule

// File: rtl/coinc_cnt_array.sv
// One wrapping counter per coincidence pattern.
module coinc_cnt_array #(
  parameter int N_DET = 4,
  parameter int CNT_W = 40,
  localparam int NUM_CNT = 1 << N_DET
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            inc,
  input  logic [N_DET-1:0]                idx,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_o
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hit, en;

    always_comb begin
      hit   = inc && (idx == N_DET'(i));
      en    = clr || hit;
      cnt_d = clr ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt_q <= '0;
      else if (en) cnt_q <= cnt_d;
    end

    assign cnt_o[i] = cnt_q;
  end
endmodule

// File: rtl/coinc_bank.sv
// Coincidence counter bank, top level.
module coinc_bank
  import coinc_pkg::*;
#(
  parameter int N_DET = 4,
  parameter int CNT_W = 40,
  localparam int NB      = CNT_W / 8,
  localparam int NUM_CNT = 1 << N_DET,
  localparam int IDX_W   = N_DET + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DET-1:0] det_i,
  input  logic             count_en,
  input  logic             clear_all,
  input  logic [NB-1:0]    preset_stb,
  input  logic [7:0]       preset_byte,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_value,
  output logic             running
);
  op_e                          op;
  logic [N_DET-1:0]             fresh_q;
  logic [CNT_W-1:0]             run_q;
  logic                         live;
  logic                         inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

  always_comb begin
    if (clear_all)        op = OP_CLEAR;
    else if (|preset_stb) op = OP_PRESET;
    else if (count_en)    op = OP_COUNT;
    else                  op = OP_IDLE;
  end

  assign inc = (op == OP_COUNT) && live;

  coinc_edge #(.N_DET(N_DET)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .det_i   (det_i),
    .fresh_o (fresh_q)
  );

  coinc_run_ctr #(.CNT_W(CNT_W)) u_run (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .preset_stb  (preset_stb),
    .preset_byte (preset_byte),
    .run_o       (run_q),
    .live_o      (live),
    .running_o   (running)
  );

  coinc_cnt_array #(.N_DET(N_DET), .CNT_W(CNT_W)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (op == OP_CLEAR),
    .inc   (inc),
    .idx   (fresh_q),
    .cnt_o (cnt_q)
  );

  always_comb begin
    if (rd_idx < IDX_W'(NUM_CNT))       rd_value = cnt_q[rd_idx[N_DET-1:0]];
    else if (rd_idx == IDX_W'(NUM_CNT)) rd_value = run_q;
    else                                rd_value = '0;
  end
endmodule

// File: rtl/coinc_bank_chk.sv
// Property checker attached to coinc_bank.
module coinc_bank_chk #(
  parameter int N_DET = 4,
  parameter int CNT_W = 40,
  localparam int NB = CNT_W / 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_DET-1:0] det_i,
  input logic             count_en,
  input logic             clear_all,
  input logic [NB-1:0]    preset_stb,
  input logic [7:0]       preset_byte,
  input logic [CNT_W-1:0] run_q,
  input logic             running,
  input logic [N_DET-1:0] fresh_q
);
  // R2: a flagged bit needs its line high on the sampling edge
  p_fresh_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh_q & ~$past(det_i)) == '0);

  // R4: counting with pulses left decrements and raises running
  p_run_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !clear_all && preset_stb == '0 && run_q != '0)
      |=> (run_q == $past(run_q) - CNT_W'(1)) && running);

  // R5: exhausted run ignores count and drops running
  p_run_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !clear_all && preset_stb == '0 && run_q == '0)
      |=> (run_q == '0) && !running);

  // R6: clear wins and zeroes the run counter
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (run_q == '0) && !running);

  // R8: no command, no change
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !clear_all && preset_stb == '0)
      |=> $stable(run_q) && $stable(running));

  for (genvar b = 0; b < NB; b++) begin : g_byte
    // R7: strobed byte is loaded
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (preset_stb[b] && !clear_all) |=> run_q[8*b +: 8] == $past(preset_byte));
    // R7: unstrobed byte is untouched during a preset
    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!preset_stb[b] && preset_stb != '0 && !clear_all)
        |=> $stable(run_q[8*b +: 8]));
  end
endmodule

bind coinc_bank coinc_bank_chk #(.N_DET(N_DET), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .det_i       (det_i),
  .count_en    (count_en),
  .clear_all   (clear_all),
  .preset_stb  (preset_stb),
  .preset_byte (preset_byte),
  .run_q       (run_q),
  .running     (running),
  .fresh_q     (fresh_q)
);

// File: tb/coinc_bank_tb.sv
`timescale 1ns/1ps
module coinc_bank_tb;
  localparam int N_DET   = 4;
  localparam int CNT_W   = 40;
  localparam int NB      = CNT_W / 8;
  localparam int NUM_CNT = 1 << N_DET;
  localparam int IDX_W   = N_DET + 1;
  localparam longint unsigned MASK = (64'd1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N_DET-1:0] det_i;
  logic             count_en;
  logic             clear_all;
  logic [NB-1:0]    preset_stb;
  logic [7:0]       preset_byte;
  logic [IDX_W-1:0] rd_idx;
  logic [CNT_W-1:0] rd_value;
  logic             running;

  int checks = 0;
  int errors = 0;
  string req_tag = "R1";

  coinc_bank #(.N_DET(N_DET), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .det_i(det_i), .count_en(count_en),
    .clear_all(clear_all), .preset_stb(preset_stb), .preset_byte(preset_byte),
    .rd_idx(rd_idx), .rd_value(rd_value), .running(running)
  );

  always #5 clk = ~clk;

  // Behavioural reference model
  longint unsigned m_cnt [NUM_CNT+1];
  bit              m_running;
  int              m_fresh, m_armed;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_running = 0; m_fresh = 0; m_armed = 0;
    end else begin
      if (clear_all) begin
        foreach (m_cnt[i]) m_cnt[i] = 0;
        m_running = 0;
      end else if (preset_stb != 0) begin
        for (int b = 0; b < NB; b++)
          if (preset_stb[b]) begin
            m_cnt[NUM_CNT] = m_cnt[NUM_CNT] & ~(64'hFF << (8*b));
            m_cnt[NUM_CNT] = m_cnt[NUM_CNT] | (longint'(preset_byte) << (8*b));
          end
      end else if (count_en) begin
        if (m_cnt[NUM_CNT] != 0) begin
          m_cnt[m_fresh]  = (m_cnt[m_fresh] + 1) & MASK;
          m_cnt[NUM_CNT]  = m_cnt[NUM_CNT] - 1;
          m_running = 1;
        end else begin
          m_running = 0;
        end
      end
      m_fresh = int'(det_i) & m_armed;
      m_armed = ~int'(det_i) & (NUM_CNT - 1);
    end
  end

  task automatic compare_all();
    for (int i = 0; i < (1 << IDX_W); i++) begin
      longint unsigned exp;
      string tag;
      rd_idx = IDX_W'(i);
      #0.01;
      exp = (i <= NUM_CNT) ? m_cnt[i] : 0;
      tag = (i > NUM_CNT) ? "R9" : req_tag;
      checks++;
      if (64'(rd_value) != exp) begin
        errors++;
        $display("FAIL %s idx %0d actual %0h expected %0h", tag, i, rd_value, exp);
      end
    end
    checks++;
    if (running !== m_running) begin
      errors++;
      $display("FAIL %s running actual %0b expected %0b", req_tag, running, m_running);
    end
  endtask

  // Compare the result of the previous edge, then apply new inputs.
  task automatic step(input logic [N_DET-1:0] d, input logic ce, input logic clr,
                      input logic [NB-1:0] stb, input logic [7:0] pb, input string tag);
    @(negedge clk);
    compare_all();
    req_tag = tag;
    det_i = d; count_en = ce; clear_all = clr; preset_stb = stb; preset_byte = pb;
  endtask

  task automatic cnt(input logic [N_DET-1:0] d, input string tag);
    step(d, 1'b1, 1'b0, '0, 8'h00, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    det_i = '1; count_en = 1'b1; clear_all = 1'b0; preset_stb = '0;
    preset_byte = 8'h00; rd_idx = '0;
    repeat (2) @(posedge clk);
    #1; req_tag = "R1";
    compare_all();                       // R1 during reset
    @(negedge clk);
    rst_n = 1'b1;
    det_i = '0; count_en = 1'b0;
    // R8 idle, R1 after release
    step('0, 0, 0, '0, 8'h00, "R8");
    step(4'h5, 0, 0, '0, 8'h00, "R8");
    // R7 byte presets, including overwrite of one byte
    step('0, 0, 0, 5'b00100, 8'hAB, "R7");
    step('0, 0, 0, 5'b00001, 8'd40, "R7");
    step('0, 0, 0, 5'b00100, 8'h00, "R7");
    step('0, 0, 0, 5'b10000, 8'h00, "R7");
    // R3 none-fired index, R2 held and overlapped lines, R4 counting
    cnt(4'h0, "R4");
    cnt(4'h0, "R3");
    cnt(4'h1, "R3");
    cnt(4'h1, "R2");
    cnt(4'h1, "R2");
    cnt(4'h0, "R2");
    cnt(4'h3, "R3");
    cnt(4'h2, "R2");
    cnt(4'h0, "R2");
    cnt(4'h4, "R3");
    cnt(4'hC, "R2");
    cnt(4'hF, "R3");
    cnt(4'h0, "R3");
    cnt(4'hF, "R3");
    cnt(4'h0, "R4");
    // R7 preset wins over count
    step(4'h8, 1, 0, 5'b00010, 8'h00, "R7");
    cnt(4'h0, "R4");
    // R2 pattern with no count edge is still registered once
    step(4'h2, 0, 0, '0, 8'h00, "R8");
    cnt(4'h0, "R3");
    // R5 exhaust the run counter
    for (int k = 0; k < 40; k++) cnt(4'(k % 3), "R5");
    cnt(4'h6, "R5");
    cnt(4'h0, "R5");
    // R6 clear with count and preset also asserted
    step(4'h0, 1, 1, 5'b11111, 8'h77, "R6");
    step(4'h0, 0, 0, '0, 8'h00, "R6");
    // R7 full-width preset, then R4 counting from a large value
    step('0, 0, 0, 5'b00001, 8'h02, "R7");
    step('0, 0, 0, 5'b01110, 8'hFF, "R7");
    step('0, 0, 0, 5'b10000, 8'h80, "R7");
    cnt(4'h9, "R4");
    cnt(4'h0, "R4");
    cnt(4'h6, "R4");
    cnt(4'h0, "R4");
    step(4'hF, 0, 0, '0, 8'h00, "R8");
    step(4'h0, 0, 0, '0, 8'h00, "R9");
    @(negedge clk);
    compare_all();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule